// File: doc/BRIEF.md
# Dual Programmable Clock Output Unit

This block drives two external clock pins, channel A and channel B, from one internal source clock. Each channel has its own 8-bit control register on a byte-wide register bus. In that register software picks a division ratio of 1, 2 or 4 and turns the pin drive on or off. Both channels share the source but run their own dividers, so the two pins can carry different frequencies at the same time.

The block runs on `clk`, which runs at twice the source frequency. One source period is therefore two `clk` cycles. Every output is a flop output, so each output edge falls on a rising edge of `clk`. A channel's half-period is 1, 2 or 4 `clk` cycles. When software turns a channel on or off, the change takes effect only while that channel's output is low. A disabled output sits low.

The register bus is synchronous to `clk`. A write is captured on the rising edge where `bus_wr` is high. The read data is a combinational decode of `bus_addr`. Addresses that map to no register read as zero and ignore writes.

Top module: `clkout_pair`

## Requirements
- R1: After reset, both control registers read 0x00 and both clock outputs are low.
- R2: Channel A's register is at byte address 0x5064 and channel B's at 0x5065. Bit 0 enables the channel and bits 5:4 hold the ratio code. A write to either register stores both fields, and reading the register returns them, code 3 included.
- R3: Bits 7:6 and 3:1 of a control register always read 0, whatever was written. Any other address reads 0x00, and a write to it changes no register and no output.
- R4: Ratio code 0 gives a high of 1 cycle and a low of 1 cycle. Code 1 gives 2 and 2 cycles, and code 2 gives 4 and 4 cycles. The duty cycle is 50 % in every case.
- R5: Ratio code 3 produces the same waveform as code 0.
- R6: While a channel's enable is 0, its output stays low.
- R7: An enable change acts only while the output is low. Clearing the enable during a high phase lets that high phase finish at full length. Setting the enable from the off state makes the first rise come on the 5th `clk` rising edge after the write edge with code 2, and in general after one low half-period plus one edge of enable capture.
- R8: While a channel is enabled, no high pulse and no low pulse is shorter than the half-period in force for that phase.
- R9: A write that changes a channel's ratio code restarts that channel's divider count at zero. The current phase then runs one full old half-period from the write. The new ratio takes over from the next low phase.
- R10: The two channels are independent. Writing one channel's register changes neither the other channel's register nor its waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate source clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge of clk |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| clk_out_a | output | 1 | Channel A clock output |
| clk_out_b | output | 1 | Channel B clock output |

## Verification
The bench goes after the moments when the output is most likely to break: clearing the enable in the middle of a high phase, setting it while the output is low, and changing the ratio partway through a phase. A design that gated the output combinationally, or that applied the enable without waiting for a low phase, would cut a high pulse short. The pulse monitor flags that, and so does the per-cycle model comparison. A design that took a new ratio straight away, or that never reset its count on a change, would produce one wrong half-period. The cycle-by-cycle comparison exposes that. Directed checks cover the remaining cases: code 3 aliasing to divide-by-1, reserved bits reading back as zero, and a write to an unmapped address. A design that stored reserved bits or decoded the address loosely would fail those reads, or a channel would change when it should not.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

  // Ratio code as stored in a control register
  typedef logic [1:0] ratio_code_t;

  // Longest half-period in clk cycles, and the widths derived from it
  localparam int unsigned MAX_HALF = 4;
  localparam int unsigned HALF_W   = $clog2(MAX_HALF) + 1;
  localparam int unsigned HELD_W   = HALF_W + 1;

  typedef logic [HALF_W-1:0] half_t;

  // Half-period in clk cycles for a ratio code: 1 -> 2, 2 -> 4, 0 and 3 -> 1
  function automatic half_t half_of(input ratio_code_t code);
    half_t h;
    case (code)
      2'd1:    h = half_t'(2);
      2'd2:    h = half_t'(4);
      default: h = half_t'(1);
    endcase
    return h;
  endfunction

  // Mask of the bits that a control register actually implements
  function automatic logic [7:0] live_mask(input int unsigned en_bit,
                                           input int unsigned ratio_lsb);
    logic [7:0] m;
    m = '0;
    m[en_bit]          = 1'b1;
    m[ratio_lsb]       = 1'b1;
    m[ratio_lsb + 1]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int unsigned N_CH      = 2,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE      = 16'h5064,
  parameter int unsigned EN_BIT    = 0,
  parameter int unsigned RATIO_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic [N_CH-1:0]      en_req,
  output ratio_code_t          code    [N_CH],
  output logic [N_CH-1:0]      restart
);

  localparam logic [7:0] LIVE = live_mask(EN_BIT, RATIO_LSB);

  logic [N_CH-1:0] hit;
  logic [7:0]      rd_word [N_CH];

  // Incoming field values, taken once from the write data
  ratio_code_t wr_code;
  logic        wr_en;
  assign wr_code = bus_wdata[RATIO_LSB +: 2];
  assign wr_en   = bus_wdata[EN_BIT];

  for (genvar i = 0; i < N_CH; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + i);

    logic        en_q;
    ratio_code_t code_q;

    assign hit[i] = (bus_addr == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        code_q <= 2'd0;
      end else if (bus_wr && hit[i]) begin
        en_q   <= wr_en;
        code_q <= wr_code;
      end
    end

    // Restart request: a write that changes the stored ratio code
    assign restart[i] = bus_wr && hit[i] && (wr_code != code_q);
    assign en_req[i]  = en_q;
    assign code[i]    = code_q;

    always_comb begin
      rd_word[i]                  = '0;
      rd_word[i][EN_BIT]          = en_q;
      rd_word[i][RATIO_LSB +: 2]  = code_q;
    end

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit[i]) |=> (code_q == $past(wr_code) && en_q == $past(wr_en))) // R2
      else $error("register %0d did not store written fields", i);
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (hit[i]) bus_rdata = bus_rdata | rd_word[i];
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~LIVE) == 8'h00)) // R3
    else $error("reserved read bits not zero");

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (bus_rdata == 8'h00)) // R3
    else $error("unmapped address returned data");

endmodule

// File: rtl/clkout_chan.sv
`timescale 1ns/1ps
module clkout_chan
  import clkout_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_req,
  input  ratio_code_t code,
  input  logic        restart,
  output logic        clk_o
);

  logic              en_q;
  logic              out_q;
  half_t             cnt_q;
  half_t             half_q;
  logic [HELD_W-1:0] held_q;

  half_t half_new;
  assign half_new = half_of(code);

  // Named events for the assertions
  logic go_off_ev;   // enable cleared while output is low
  logic end_ev;      // current half-period has run out
  logic toggle_ev;   // output changes level this edge
  assign go_off_ev = en_q && !en_req && !out_q;
  assign end_ev    = (cnt_q == half_q - 1'b1);
  assign toggle_ev = en_q && !go_off_ev && !restart && end_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= half_t'(1);
    end else if (!en_q) begin
      out_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= half_new;
      en_q   <= en_req;
    end else if (go_off_ev) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (restart) begin
      cnt_q  <= '0;
    end else if (end_ev) begin
      cnt_q  <= '0;
      out_q  <= ~out_q;
      if (out_q) half_q <= half_new;   // falling edge: next low uses new ratio
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // Cycles the output has held its level; support for the pulse-width check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 held_q <= HELD_W'(1);
    else if (toggle_ev)         held_q <= HELD_W'(1);
    else if (held_q != '1)      held_q <= held_q + 1'b1;
  end

  assign clk_o = out_q;

  AST_EN_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_q) || $fell(en_q)) |-> !$past(out_q)) // R7
    else $error("enable changed while output high");

  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !$past(en_q)) |-> !out_q) // R6
    else $error("output high while disabled");

  AST_HALF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(half_q) == 1 && half_q <= half_t'(MAX_HALF))) // R5
    else $error("illegal half-period");

  AST_NO_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_ev |-> (held_q >= {1'b0, half_q})) // R8
    else $error("output pulse shorter than half-period");

endmodule

// File: rtl/clkout_pair.sv
`timescale 1ns/1ps
module clkout_pair
  import clkout_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BASE      = 16'h5064,
  parameter int unsigned EN_BIT    = 0,
  parameter int unsigned RATIO_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              clk_out_a,
  output logic              clk_out_b
);

  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0] en_req;
  ratio_code_t     code [N_CH];
  logic [N_CH-1:0] restart;
  logic [N_CH-1:0] outs;

  clkout_regs #(
    .N_CH      (N_CH),
    .ADDR_W    (ADDR_W),
    .BASE      (BASE),
    .EN_BIT    (EN_BIT),
    .RATIO_LSB (RATIO_LSB)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en_req    (en_req),
    .code      (code),
    .restart   (restart)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    clkout_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_req  (en_req[i]),
      .code    (code[i]),
      .restart (restart[i]),
      .clk_o   (outs[i])
    );
  end

  assign clk_out_a = outs[0];
  assign clk_out_b = outs[1];

endmodule

// File: tb/clkout_pair_tb.sv
`timescale 1ns/1ps
module clkout_pair_tb;

  localparam int BASE = 16'h5064;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        clk_out_a, clk_out_b;
  logic [1:0]  outs;
  assign outs = {clk_out_b, clk_out_a};

  always #5 clk = ~clk;

  clkout_pair u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_out_a(clk_out_a), .clk_out_b(clk_out_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: per channel, level, cycles left in phase, phase length
  int m_en[2], m_code[2], m_on[2], m_o[2], m_left[2], m_half[2];

  function automatic int half_for(input int c);
    if (c == 1) return 2;
    if (c == 2) return 4;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_en[c] = 0; m_code[c] = 0; m_on[c] = 0; m_o[c] = 0;
        m_left[c] = 1; m_half[c] = 1;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit wr_me;
        bit rs;
        wr_me = bus_wr && (bus_addr == 16'(BASE + c));
        rs    = wr_me && (int'(bus_wdata[5:4]) != m_code[c]);
        if (m_on[c] == 0) begin
          m_o[c] = 0; m_half[c] = half_for(m_code[c]); m_left[c] = m_half[c];
          m_on[c] = m_en[c];
        end else if (m_en[c] == 0 && m_o[c] == 0) begin
          m_on[c] = 0;
        end else if (rs) begin
          m_left[c] = m_half[c];
        end else if (m_left[c] == 1) begin
          m_o[c] = 1 - m_o[c];
          if (m_o[c] == 0) m_half[c] = half_for(m_code[c]);
          m_left[c] = m_half[c];
        end else begin
          m_left[c] = m_left[c] - 1;
        end
        if (wr_me) begin
          m_en[c]   = int'(bus_wdata[0]);
          m_code[c] = int'(bus_wdata[5:4]);
        end
      end
    end
  end

  // Per-cycle comparison (R4, R6, R7, R9, R10) and pulse-width monitor (R8)
  int run[2], rec_half[2], prev_lv[2];
  initial begin
    for (int c = 0; c < 2; c++) begin run[c] = 0; rec_half[c] = 1; prev_lv[c] = 0; end
  end
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        check(int'(outs[c]) == m_o[c], c == 0 ? "R4/R7/R9 model A" : "R10 model B",
              int'(outs[c]), m_o[c]);
        if (int'(outs[c]) != prev_lv[c]) begin
          if (run[c] > 0)
            check(run[c] >= rec_half[c], "R8 pulse width", run[c], rec_half[c]);
          rec_half[c] = m_half[c];
          run[c] = 1;
          prev_lv[c] = int'(outs[c]);
        end else begin
          run[c]++;
        end
      end
    end
  end

  task automatic wr(input int ch_addr, input int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 16'(ch_addr); bus_wdata = 8'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input int a, input int exp, input string tag);
    bus_addr = 16'(a);
    #1;
    check(bus_rdata == 8'(exp), tag, int'(bus_rdata), exp);
  endtask

  task automatic wait_rise(input int ch);
    int g = 0;
    int p;
    do begin
      p = int'(outs[ch]);
      @(negedge clk);
      g++;
    end while (!(p == 0 && outs[ch] == 1'b1) && g < 200);
  endtask

  task automatic measure(input int ch, input int half, input string tag);
    int hi = 0;
    int lo = 0;
    wait_rise(ch);
    while (outs[ch] == 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    while (outs[ch] == 1'b0 && lo < 100) begin lo++; @(negedge clk); end
    check(hi == half, {tag, " high length"}, hi, half);
    check(lo == half, {tag, " low length"}, lo, half);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    rd_check(BASE, 8'h00, "R1 reg A reset");
    rd_check(BASE + 1, 8'h00, "R1 reg B reset");
    check(outs == 2'b00, "R1 outputs low", int'(outs), 0);
    repeat (5) @(negedge clk);
    check(outs == 2'b00, "R6 disabled after reset", int'(outs), 0);

    // R4: each ratio on channel A
    wr(BASE, 8'h01); repeat (12) @(negedge clk); measure(0, 1, "R4 code0");
    wr(BASE, 8'h11); repeat (12) @(negedge clk); measure(0, 2, "R4 code1");
    wr(BASE, 8'h21); repeat (20) @(negedge clk); measure(0, 4, "R4 code2");
    // R5: code 3 acts as divide-by-1 and reads back as written
    wr(BASE, 8'h31); repeat (20) @(negedge clk); measure(0, 1, "R5 code3");
    rd_check(BASE, 8'h31, "R2 readback code3");

    // R3: reserved bits
    wr(BASE, 8'hFF);
    rd_check(BASE, 8'h31, "R3 reserved bits read zero");

    // R10: channel B independent
    wr(BASE + 1, 8'h21);
    rd_check(BASE + 1, 8'h21, "R2 reg B readback");
    rd_check(BASE, 8'h31, "R10 reg A untouched");
    repeat (20) @(negedge clk);
    measure(1, 4, "R10 channel B");
    measure(0, 1, "R10 channel A");

    // R3: unmapped address
    wr(BASE + 2, 8'hFF);
    rd_check(BASE + 2, 8'h00, "R3 unmapped reads zero");
    rd_check(BASE, 8'h31, "R3 reg A after stray write");
    rd_check(BASE + 1, 8'h21, "R3 reg B after stray write");

    // R7: disable during high lets it finish; R6: then stays low
    wr(BASE, 8'h21); repeat (20) @(negedge clk);
    wait_rise(0);
    wr(BASE, 8'h20);
    check(clk_out_a == 1'b1, "R7 high not cut by disable", int'(clk_out_a), 1);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      if (k % 5 == 0) check(clk_out_a == 1'b0, "R6 held low while off", int'(clk_out_a), 0);
      @(negedge clk);
    end

    // R7: enabling from off, code 2: rise on the 5th edge after the write edge
    wr(BASE, 8'h21);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check(int'(clk_out_a) == (k == 5 ? 1 : 0), "R7 enable rise timing",
            int'(clk_out_a), (k == 5 ? 1 : 0));
    end

    // R9: ratio change in the middle of a high phase
    repeat (10) @(negedge clk);
    wait_rise(0);
    wr(BASE, 8'h01);
    check(clk_out_a == 1'b1, "R9 phase restarted not cut", int'(clk_out_a), 1);
    repeat (20) @(negedge clk);
    measure(0, 1, "R9 new ratio");

    // R9: ratio change during a low phase on channel B
    wait_rise(1);
    repeat (5) @(negedge clk);
    wr(BASE + 1, 8'h11);
    repeat (20) @(negedge clk);
    measure(1, 2, "R9 channel B new ratio");

    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule